// File: doc/BRIEF.md
# Symmetric four-tap FIR decimator (rate two)

This block is a streaming, linear-phase low-pass stage with four taps. It keeps one output for every two samples it accepts. Because the impulse response is even-symmetric, the newest and oldest samples are summed first, and then the two middle samples are summed. Each pair sum is then scaled by its one coefficient. A single pre-adder, a single multiplier and a single clearable accumulator are shared by both pairs. A fixed schedule keeps every unit busy on every cycle when samples arrive back to back. The two coefficients are fixed at elaboration time through parameters.

Samples enter with a one-cycle qualifier. Results leave with a one-cycle qualifier of the same convention, so a second stage of the same kind can be attached directly to the output for a further decimation by two. The only arithmetic limits are two's-complement wrap-around at each unit width. No rounding or saturation is done. The caller must keep the two top bits of every sample equal, so that the 18-bit pair sums never overflow.

Top module: `symfir_decim2`

## Requirements
- R1: The reset is synchronous and active-low. While it is held, out_valid and out_sample read 0, and samples offered during reset are not kept. After reset, the sample history and the pairing phase restart, so the first result uses only samples accepted after reset.
- R2: Accepted samples are numbered k = 1, 2, 3 and so on after reset. Every result equals the low 18 bits of the sum H0·s0 + H1·s1. Here s0 = x(k)+x(k−3) and s1 = x(k−1)+x(k−2), each wrapped to 18 signed bits. The products are 36-bit signed values, and the sum wraps in a 36-bit accumulator.
- R3: A sample is taken only on a clock edge where in_valid is 1. On edges where in_valid is 0, in_sample is ignored and the schedule stalls. Gaps of any length leave the results unchanged from an unbroken stream of the same accepted samples.
- R4: A result is produced only for even k with k ≥ 4. Nothing is output before the fourth accepted sample, and with samples on every cycle a result appears every second cycle.
- R5: Let the sample that completes a result be accepted at clock edge P. Then out_valid is 1 during exactly the cycle between edges P+8 and P+9, and out_sample carries that result.
- R6: out_valid is never high on two consecutive cycles. out_sample keeps its last value on every cycle where out_valid is 0.
- R7: Samples anywhere in the legal range −65536 to 65535 (the two top bits equal) give results that match R2 exactly, including the extremes of that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample qualifier; in_sample is taken on edges where this is 1 |
| in_sample | input | 18 | Signed input sample; the two top bits must be equal |
| out_sample | output | 18 | Signed filter result, low 18 bits of the accumulator |
| out_valid | output | 1 | One-cycle pulse marking a new out_sample |

## Verification
Each result is due exactly eight rising edges after the edge that accepts the second sample of its pair. The bench stamps every expected result with that edge number when it drives the sample. It then samples the outputs half a cycle after each edge. An expected result is compared only on its stamped cycle. A pulse on any other cycle, or a missing pulse on the stamped cycle, is reported. On every cycle without a pulse, the bench checks that out_sample holds its value, which covers the case where the output changes while qualified as idle.

// File: rtl/symfir_pkg.sv
// Schedule constants shared by the decimator and its submodules.
// The slot numbers of the controller schedule follow from the unit latencies,
// so changing a latency here moves every dependent slot with it.
package symfir_pkg;
    localparam int unsigned TAPS      = 4;
    localparam int unsigned ADD_LAT   = 2;
    localparam int unsigned MUL_LAT   = 2;
    localparam int unsigned SL_PAIR_A = 0;
    localparam int unsigned SL_PAIR_B = SL_PAIR_A + 1;
    localparam int unsigned SL_COEF_A = SL_PAIR_A + ADD_LAT;
    localparam int unsigned SL_COEF_B = SL_COEF_A + 1;
    localparam int unsigned SL_CLR_A  = SL_COEF_A + MUL_LAT;
    localparam int unsigned SL_CLR_B  = SL_CLR_A + 2;
    localparam int unsigned SLOTS     = SL_CLR_B + 1;
endpackage

// File: rtl/symfir_ctrl.sv
// Controller: keeps the four-sample history and the pairing phase, and plays
// a fixed slot schedule for each completed pair of samples. Slot 0 drives the
// outer pair into the pre-adder. The next slot drives the inner pair, which is
// snapshotted so new samples may shift in meanwhile. Coefficients are timed to
// meet the matching pair sums, and the accumulator controls are timed to meet
// the matching products. Outside their slots, the operands and coefficient are
// zero. Assumes rst_n is synchronous, active low.
module symfir_ctrl
    import symfir_pkg::*;
#(
    parameter int unsigned       DW = 18,
    parameter logic signed [DW-1:0] H0 = '0,
    parameter logic signed [DW-1:0] H1 = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    output logic signed [DW-1:0] add_a,
    output logic signed [DW-1:0] add_b,
    output logic signed [DW-1:0] coef,
    output logic                 acc_clr,
    output logic                 acc_present
);
    localparam int unsigned FILL_W = $clog2(TAPS);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(TAPS - 1);

    logic [TAPS-1:0][DW-1:0] hist;
    logic [DW-1:0]           inner_hi, inner_lo;
    logic                    phase;
    logic [FILL_W-1:0]       fill;
    logic [SLOTS-1:0]        slot;

    // Shift the sample history on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (in_valid) begin
            hist[0] <= in_sample;
            for (int i = 1; i < TAPS; i++) hist[i] <= hist[i-1];
        end
    end

    // Track the pairing phase and the warm-up fill, and launch a schedule token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= 1'b0;
            fill    <= '0;
            slot[0] <= 1'b0;
        end else begin
            slot[0] <= in_valid && phase && (fill == FILL_FULL);
            if (in_valid) begin
                phase <= ~phase;
                if (fill != FILL_FULL) fill <= fill + 1'b1;
            end
        end
    end

    // Move each token one slot further down the schedule per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) slot[SLOTS-1:1] <= '0;
        else        slot[SLOTS-1:1] <= slot[SLOTS-2:0];
    end

    // Snapshot the inner pair while the outer pair is being issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inner_hi <= '0;
            inner_lo <= '0;
        end else if (slot[SL_PAIR_A]) begin
            inner_hi <= hist[1];
            inner_lo <= hist[TAPS-2];
        end
    end

    // Select the operands and controls for the current slot.
    always_comb begin
        add_a = '0;
        add_b = '0;
        if (slot[SL_PAIR_A]) begin
            add_a = hist[0];
            add_b = hist[TAPS-1];
        end else if (slot[SL_PAIR_B]) begin
            add_a = inner_hi;
            add_b = inner_lo;
        end
        coef = '0;
        if (slot[SL_COEF_A])      coef = H0;
        else if (slot[SL_COEF_B]) coef = H1;
        acc_clr     = slot[SL_CLR_A] | slot[SL_CLR_B];
        acc_present = slot[SL_CLR_B];
    end

    // Two schedule tokens are never launched back to back (R4 cadence).
    a_r4_token_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        slot[0] |=> !slot[0]);

    // The history must not move while no sample is offered (R3).
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(hist));
endmodule

// File: rtl/symfir_preadd.sv
// Shared pre-adder: adds two signed operands with wrap-around at DW bits, then
// passes the sum through a register chain. The sum appears ADD_LAT cycles after
// its operands. Assumes the caller keeps the sum in range (two top bits equal).
module symfir_preadd
    import symfir_pkg::*;
#(
    parameter int unsigned DW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] sum
);
    logic [ADD_LAT-1:0][DW-1:0] pipe;

    // Compute the sum, then carry it through the output register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= a + b;
            for (int i = 1; i < ADD_LAT; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign sum = pipe[ADD_LAT-1];
endmodule

// File: rtl/symfir_mul.sv
// Shared multiplier: forms the full-width signed product of two DW-bit
// operands. The product appears MUL_LAT cycles after its operands.
module symfir_mul
    import symfir_pkg::*;
#(
    parameter int unsigned DW = 18,
    localparam int unsigned PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [PW-1:0] prod
);
    logic [MUL_LAT-1:0][PW-1:0] pipe;

    // Multiply, then carry the product through the output register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= PW'(a) * PW'(b);
            for (int i = 1; i < MUL_LAT; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign prod = pipe[MUL_LAT-1];
endmodule

// File: rtl/symfir_acc.sv
// Clearable accumulator. When clr is high, the running sum restarts from the
// incoming product; when it is low, the product is added with wrap-around.
// When present is high, the completed sum so far is latched as a result, and
// res_vld pulses on the next cycle. Assumes present is only raised together
// with clr, after the last product of a result.
module symfir_acc #(
    parameter int unsigned AW = 36,
    parameter int unsigned DW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [AW-1:0] prod,
    input  logic                 clr,
    input  logic                 present,
    output logic signed [DW-1:0] res,
    output logic                 res_vld
);
    logic signed [AW-1:0] acc;

    // Restart or extend the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= prod;
        else          acc <= acc + prod;
    end

    // Latch the completed sum, truncated to its low bits, on a present request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res     <= '0;
            res_vld <= 1'b0;
        end else begin
            res_vld <= present;
            if (present) res <= acc[DW-1:0];
        end
    end
endmodule

// File: rtl/symfir_decim2.sv
// Top of the symmetric four-tap decimate-by-two filter. It joins the
// controller, pre-adder, multiplier and accumulator, and adds one output
// register stage, so the qualifier follows the accumulator result by a cycle.
// Assumes the two top bits of every sample are equal; rst_n is synchronous,
// active low.
module symfir_decim2
    import symfir_pkg::*;
#(
    parameter int unsigned          DW = 18,
    parameter logic signed [DW-1:0] H0 = 18'sd91000,
    parameter logic signed [DW-1:0] H1 = -18'sd23456
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    output logic signed [DW-1:0] out_sample,
    output logic                 out_valid
);
    localparam int unsigned PW = 2 * DW;

    logic signed [DW-1:0] add_a, add_b, coef, pair_sum, res;
    logic signed [PW-1:0] prod;
    logic                 acc_clr, acc_present, res_vld;

    symfir_ctrl #(.DW(DW), .H0(H0), .H1(H1)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .add_a(add_a), .add_b(add_b), .coef(coef),
        .acc_clr(acc_clr), .acc_present(acc_present)
    );

    symfir_preadd #(.DW(DW)) u_preadd (
        .clk(clk), .rst_n(rst_n), .a(add_a), .b(add_b), .sum(pair_sum)
    );

    symfir_mul #(.DW(DW)) u_mul (
        .clk(clk), .rst_n(rst_n), .a(pair_sum), .b(coef), .prod(prod)
    );

    symfir_acc #(.AW(PW), .DW(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .prod(prod), .clr(acc_clr),
        .present(acc_present), .res(res), .res_vld(res_vld)
    );

    // Register the result and its qualifier one cycle after the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= res_vld;
            if (res_vld) out_sample <= res;
        end
    end

    // Count accepted samples up to TAPS, for the warm-up check only.
    logic [$clog2(TAPS+1)-1:0] seen;
    always_ff @(posedge clk) begin
        if (!rst_n)                                  seen <= '0;
        else if (in_valid && seen != ($bits(seen))'(TAPS)) seen <= seen + 1'b1;
    end

    a_r4_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen == ($bits(seen))'(TAPS)));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample));
endmodule

// File: tb/tb_symfir_decim2.sv
// Directed bench: every scenario task drives samples a quarter cycle after a
// rising edge. A bit-exact model stamps each expected result with its due edge,
// and a monitor half a cycle after each edge compares the outputs.
module tb_symfir_decim2;
    localparam int unsigned          DW  = 18;
    localparam logic signed [DW-1:0] BH0 = 18'sd91000;
    localparam logic signed [DW-1:0] BH1 = -18'sd23456;
    localparam int                   LAT = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic signed [DW-1:0] out_sample;
    logic                 out_valid;

    symfir_decim2 #(.DW(DW), .H0(BH0), .H1(BH1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_sample(out_sample), .out_valid(out_valid)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int due; int val; } exp_t;
    exp_t  exp_q[$];
    int    checks = 0, failures = 0, n_out = 0, n_exp = 0, n_acc = 0;
    int    hist[4] = '{0, 0, 0, 0};
    int    last_out = 0;
    string cur_req = "R1";
    bit    finished = 0;

    function automatic void check(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endfunction

    function automatic int ref_y(int a0, int a1, int a2, int a3);
        logic signed [DW-1:0] sa, sb, r;
        longint t;
        sa = 18'(a0 + a3);
        sb = 18'(a1 + a2);
        t  = longint'(sa) * longint'(BH0) + longint'(sb) * longint'(BH1);
        r  = t[DW-1:0];
        return int'(r);
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(bit v, int x);
        step();
        in_valid  = v;
        in_sample = 18'(x);
        if (v) begin
            hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = x;
            n_acc++;
            if (n_acc >= 4 && n_acc % 2 == 0) begin
                exp_q.push_back('{due: cyc + 1 + LAT, val: ref_y(hist[0], hist[1], hist[2], hist[3])});
                n_exp++;
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 54321);
    endtask

    function automatic int legal(int i, int seed);
        return ((i * 7919 + seed * 104729) % 131072 + 131072) % 131072 - 65536;
    endfunction

    // Monitor: compare on due cycles, flag stray pulses, check the hold otherwise.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                check(cur_req, "out_valid on due cycle", int'(out_valid), 1);
                check(cur_req, "out_sample value", int'(out_sample), exp_q[0].val);
                exp_q.delete(0);
                last_out = int'(out_sample);
                n_out++;
            end else if (out_valid) begin
                check(cur_req, "out_valid off due cycle", 1, 0);
                n_out++;
            end else begin
                check("R6", "out_sample held while idle", int'(out_sample), last_out);
            end
        end
    end

    task automatic do_reset();
        step();
        rst_n = 1'b0; in_valid = 1'b1; in_sample = 18'sd777;
        repeat (3) step();
        check("R1", "out_valid during reset", int'(out_valid), 0);
        check("R1", "out_sample during reset", int'(out_sample), 0);
        n_acc = 0; hist = '{0, 0, 0, 0}; last_out = 0;
        rst_n = 1'b1; in_valid = 1'b0;
    endtask

    task automatic t_warmup();
        int b_out;
        cur_req = "R4";
        b_out = n_out;
        for (int i = 0; i < 3; i++) drive(1'b1, legal(i, 1));
        idle(14);
        check("R4", "results before fourth sample", n_out - b_out, 0);
        drive(1'b1, legal(3, 1));
        idle(14);
        check("R4", "results after fourth sample", n_out - b_out, 1);
    endtask

    task automatic t_stream();
        int b_out, b_exp;
        cur_req = "R5";
        b_out = n_out; b_exp = n_exp;
        for (int i = 0; i < 24; i++) drive(1'b1, legal(i, 2));
        idle(14);
        check("R5", "results from back-to-back stream", n_out - b_out, n_exp - b_exp);
        check("R4", "one result per two samples", n_exp - b_exp, 12);
    endtask

    task automatic t_gaps();
        int b_out, b_exp;
        cur_req = "R3";
        b_out = n_out; b_exp = n_exp;
        for (int i = 0; i < 16; i++) begin
            drive(1'b1, legal(i, 3));
            for (int g = 0; g < (i % 4); g++) drive(1'b0, (g % 2 == 0) ? 65535 : -65536);
        end
        idle(14);
        check("R3", "results with gapped enable", n_out - b_out, n_exp - b_exp);
    endtask

    task automatic t_extremes();
        int b_out, b_exp;
        int pat[8] = '{65535, 65535, 65535, 65535, -65536, -65536, -65536, -65536};
        cur_req = "R7";
        b_out = n_out; b_exp = n_exp;
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 8; i++) drive(1'b1, pat[i]);
        for (int i = 0; i < 8; i++) drive(1'b1, (i % 2 == 0) ? 65535 : -65536);
        idle(14);
        check("R7", "results at range extremes", n_out - b_out, n_exp - b_exp);
        cur_req = "R2";
        b_out = n_out; b_exp = n_exp;
        for (int i = 0; i < 10; i++) drive(1'b1, (i * 13001) % 65536 - 32768);
        idle(14);
        check("R2", "results for ramp pattern", n_out - b_out, n_exp - b_exp);
    endtask

    task automatic t_midreset();
        int b_out;
        cur_req = "R1";
        for (int i = 0; i < 5; i++) drive(1'b1, legal(i, 4));
        idle(14);
        do_reset();
        b_out = n_out;
        for (int i = 0; i < 3; i++) drive(1'b1, legal(i, 5));
        idle(14);
        check("R1", "no result from pre-reset history", n_out - b_out, 0);
        drive(1'b1, legal(3, 5));
        idle(14);
        check("R1", "first result after reset", n_out - b_out, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    initial begin
        do_reset();
        t_warmup();
        t_stream();
        t_gaps();
        t_extremes();
        t_midreset();
        check("R5", "no result left pending", exp_q.size(), 0);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("R5", "watchdog expired", 1, 0);
        summary();
        $finish;
    end
endmodule